// File: doc/BRIEF.md
# 1-Wire Slave Reset Detector

This block sits at the bus edge of a 1-Wire slave. It brings the shared line into the clock domain through a two-flop synchronizer and counts the clock cycles for which the synchronized line stays low. The line idles high. A low period that runs past a speed-dependent limit counts as a bus reset. The block then raises an abort flag while the limit is exceeded, and it emits a one-cycle reset indication when the line is released.

The limit is 120 µs in standard mode and 16 µs in overdrive mode, converted to cycles from a clock-frequency parameter. The mode comes from a speed-select pin, which the block captures only while the bus is idle, so a change in the middle of a low period has no effect. The block also gates the slave's request to pull the line low. The resulting enable is meant to drive an open-drain pad: it can only pull low or release the line, and it is held off while a reset condition is being reported.

Top module: `owire_rst_detect`

## Requirements
- R1: After reset, `rst_seen`, `abort` and `speed_mode` are 0, and `pull_en` is 0 when `drive_low_req` is 0.
- R2: In standard mode (`speed_mode`=0) a reset is recognised when the synchronized line stays low for more than `(CLK_HZ/1_000_000)*120` clock cycles. A shorter or equal low time is not a reset.
- R3: In overdrive mode (`speed_mode`=1) the limit is `(CLK_HZ/1_000_000)*16` clock cycles, with the same strict comparison.
- R4: A recognised reset produces exactly one `rst_seen` pulse, one cycle wide. It is high in the third clock cycle after `bus_in` returns high: two cycles of synchronizer and one output register.
- R5: `abort` is high while the measured low time exceeds the active limit. It is never high for a low time at or under the limit, and it drops once the line is back high.
- R6: `speed_mode` loads `speed_fast` (0 = standard, 1 = overdrive) one cycle later in every cycle where the synchronized line is high. While the line is low it holds its value, and a change of `speed_fast` during that time has no effect on the limit.
- R7: The low-time counter saturates instead of wrapping, so a low period many times the limit still yields `abort` high at its end and exactly one `rst_seen` pulse.
- R8: `pull_en` equals `drive_low_req` except that it is forced to 0 while `abort` or `rst_seen` is high. The block has no output that drives the line high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Raw sample of the bus line (1 = released/high) |
| speed_fast | input | 1 | Speed select: 0 standard, 1 overdrive |
| drive_low_req | input | 1 | Request from slave logic to pull the line low |
| rst_seen | output | 1 | One-cycle pulse after a qualifying low period ends |
| abort | output | 1 | High while the current low time exceeds the limit |
| speed_mode | output | 1 | Latched speed mode in use for the limit |
| pull_en | output | 1 | Open-drain pull-down enable (1 = pull low) |

## Verification
Every low-pulse length from one cycle up past the limit is applied in both modes, with the clock set so that the limits are 120 and 16 cycles. This separates a correct strict "greater than" comparison from an off-by-one, and separates the overdrive limit from the standard one. A low period several times the limit shows whether the counter saturates or wraps. A speed change made in the middle of a low period shows whether the mode is truly frozen while the line is low. Holding the pull-down request during idle, abort and the reset pulse shows the gating of the drive enable.

// File: rtl/owire_rst_detect.sv
module owire_rst_detect #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int STD_US  = 120,
  parameter int FAST_US = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  input  logic speed_fast,
  input  logic drive_low_req,
  output logic rst_seen,
  output logic abort,
  output logic speed_mode,
  output logic pull_en
);

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int THR_STD    = CYC_PER_US * STD_US;
  localparam int THR_FAST   = CYC_PER_US * FAST_US;
  localparam int THR_MAX    = (THR_STD > THR_FAST) ? THR_STD : THR_FAST;
  localparam int CNT_SAT    = THR_MAX + 1;
  localparam int CW         = $clog2(CNT_SAT + 1);

  localparam logic [CW-1:0] LIM_STD  = CW'(THR_STD);
  localparam logic [CW-1:0] LIM_FAST = CW'(THR_FAST);
  localparam logic [CW-1:0] LIM_SAT  = CW'(CNT_SAT);

  logic          sync1, bus_s;
  logic [CW-1:0] low_cnt;
  logic [CW-1:0] limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      bus_s <= 1'b1;
    end else begin
      sync1 <= bus_in;
      bus_s <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      low_cnt <= '0;
    else if (bus_s)
      low_cnt <= '0;
    else if (low_cnt != LIM_SAT)
      low_cnt <= low_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      speed_mode <= 1'b0;
    else if (bus_s)
      speed_mode <= speed_fast;
  end

  assign limit = speed_mode ? LIM_FAST : LIM_STD;
  assign abort = (low_cnt > limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_seen <= 1'b0;
    else
      rst_seen <= bus_s & abort;
  end

  assign pull_en = drive_low_req & ~abort & ~rst_seen;

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seen |=> !rst_seen);

  // R5
  abort_before_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_seen |-> ($past(abort) && !abort));

  // R6
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_s |=> $stable(speed_mode));

  // R7
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_cnt <= LIM_SAT);

  // R8
  pull_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pull_en |-> (drive_low_req && !rst_seen));

endmodule

// File: tb/owire_rst_detect_bench.sv
`timescale 1ns/1ps
module owire_rst_detect_bench;

  localparam int CLK_HZ = 1_000_000;
  localparam int T_STD  = 120;
  localparam int T_FAST = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_in = 1'b1;
  logic speed_fast = 1'b0;
  logic drive_low_req = 1'b0;
  logic rst_seen, abort, speed_mode, pull_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  owire_rst_detect #(.CLK_HZ(CLK_HZ), .STD_US(120), .FAST_US(16)) u_owire_rst_detect (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .speed_fast(speed_fast),
    .drive_low_req(drive_low_req), .rst_seen(rst_seen), .abort(abort),
    .speed_mode(speed_mode), .pull_en(pull_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive low for len cycles, then observe; returns pulses, pulse position, abort seen
  task automatic low_pulse(input int len, output int pulses, output int pos, output bit saw_ab,
                           output bit ab_end);
    pulses = 0; pos = -1; saw_ab = 1'b0;
    bus_in = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (abort) saw_ab = 1'b1;
    end
    ab_end = abort;
    bus_in = 1'b1;
    for (int i = 1; i <= 7; i++) begin
      @(negedge clk);
      if (abort && i < 3) saw_ab = 1'b1;
      if (rst_seen) begin pulses++; pos = i; end
    end
  endtask

  task automatic sweep(input bit fast, input int thr, input int maxlen, input string req);
    int p, ps; bit sa, ae; bit exp;
    speed_fast = fast;
    idle(3);
    chk(speed_mode == fast, "R6", speed_mode, fast);
    for (int len = 1; len <= maxlen; len++) begin
      low_pulse(len, p, ps, sa, ae);
      exp = (len > thr);
      chk(p == int'(exp), req, p, int'(exp));
      chk(sa == exp, "R5", sa, exp);
      if (exp) chk(ps == 3, "R4", ps, 3);
      chk(abort == 1'b0, "R5", abort, 0);
      idle(2);
    end
  endtask

  initial begin
    int p, ps; bit sa, ae;
    idle(3);
    chk(rst_seen == 0, "R1", rst_seen, 0);
    chk(abort == 0, "R1", abort, 0);
    chk(speed_mode == 0, "R1", speed_mode, 0);
    chk(pull_en == 0, "R1", pull_en, 0);
    rst_n = 1'b1;
    idle(4);

    sweep(1'b0, T_STD, T_STD + 10, "R2");
    sweep(1'b1, T_FAST, T_FAST + 10, "R3");

    // R6: speed change during low has no effect
    speed_fast = 1'b0;
    idle(3);
    bus_in = 1'b0;
    idle(10);
    speed_fast = 1'b1;
    idle(30);
    chk(speed_mode == 0, "R6", speed_mode, 0);
    chk(abort == 0, "R6", abort, 0);
    bus_in = 1'b1;
    p = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (rst_seen) p++; end
    chk(p == 0, "R6", p, 0);
    chk(speed_mode == 1, "R6", speed_mode, 1);
    speed_fast = 1'b0;
    idle(3);

    // R7: very long low, saturation
    low_pulse(4 * T_STD + 37, p, ps, sa, ae);
    chk(ae == 1'b1, "R7", ae, 1);
    chk(p == 1, "R7", p, 1);
    idle(3);

    // R8: pull-down gating
    drive_low_req = 1'b1;
    @(negedge clk);
    chk(pull_en == 1, "R8", pull_en, 1);
    bus_in = 1'b0;
    idle(T_STD + 5);
    chk(abort == 1 && pull_en == 0, "R8", pull_en, 0);
    bus_in = 1'b1;
    idle(2);
    chk(rst_seen == 0 && pull_en == 0, "R8", pull_en, 0);
    @(negedge clk);
    chk(rst_seen == 1, "R4", rst_seen, 1);
    chk(pull_en == 0, "R8", pull_en, 0);
    @(negedge clk);
    chk(pull_en == 1, "R8", pull_en, 1);
    drive_low_req = 1'b0;
    @(negedge clk);
    chk(pull_en == 0, "R8", pull_en, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150_000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule